// File: doc/BRIEF.md
# Manchester Receive Decoder with Carrier Sense

This block turns an oversampled Manchester line into NRZ receive data, a receive clock and a carrier-sense flag. Its input is a single bit that has already passed a squelch stage. The block samples that bit once per clock, at eight samples per bit cell. The line rests low when idle. A digital phase tracker measures the time between transitions. It treats transitions that fall about one cell after the last mid-bit transition as mid-bit, and transitions about half a cell after it as cell boundaries. Each decoded bit is the line level in the second half of its cell.

Carrier sense rises on the first transition. A short acquisition phase must see a run of evenly spaced mid-bit transitions before any bit is delivered. When the expected mid-bit transition does not arrive, carrier sense drops. The receive clock then runs on by itself for five bit times and is then held low until the next frame starts. A loopback input selects the local encoder's serial output in place of the line input.

Top module: `mdec_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `crs`, `rxd` and `rxc` are 0.
- R2: `crs` reads 1 two rising clock edges after the first transition of the selected input leaves the idle state.
- R3: Before lock, no bits are delivered and `rxc` stays low. Lock is reached on the fourth transition in a row, counting the first one, whose spacing is a mid-bit spacing. That fourth transition delivers the first bit.
- R4: On each accepted mid-bit transition after lock, `rxd` takes the input level that follows the transition. So 1 is a low-to-high and 0 a high-to-low mid-cell transition.
- R5: After each delivered bit, `rxc` is 0 in the cycle in which `rxd` changes. It is then 1 for the next four cycles. `rxd` does not change while `rxc` is 1.
- R6: Spacing is counted in samples since the last accepted mid-bit transition. A transition at a spacing of 6 to 10 is mid-bit; one at 3 to 5 is a boundary and is ignored. A jitter of ±1 sample on each mid-bit transition is decoded without error.
- R7: If no mid-bit transition arrives by a spacing of 10 samples after lock, `crs` falls in the following cycle. This is no later than 1.5 bit times after the end of the last cell.
- R8: After `crs` falls from lock, `rxc` gives exactly five pulses with a period of 8 cycles, each 4 cycles high. It then stays 0 until a new transition starts a new frame.
- R9: With `loop_en` at 1, the decoder takes `enc_in` and ignores `line_in` entirely. With `loop_en` at 0, it takes `line_in`.
- R10: Before lock, a transition at a spacing under 3 samples restarts acquisition from that transition. A spacing of more than 10 samples without a mid-bit transition returns the block to idle with `crs` low and no `rxc` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, eight times the bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| loop_en | input | 1 | 1 selects the local encoder output as the decoder input |
| line_in | input | 1 | Squelched line data, idle low |
| enc_in | input | 1 | Local encoder serial output, used in loopback |
| crs | output | 1 | Carrier sense |
| rxd | output | 1 | Recovered NRZ data |
| rxc | output | 1 | Recovered receive clock, rising while rxd is stable |

## Verification
If the spacing counter holds a wrong phase, mid-bit transitions are classified as boundaries. The first sign at the ports is `crs` dropping, or a missing `rxc` pulse, within about ten samples. A wrong lock count shows as the first delivered bit arriving one cell early or late. A bad tail counter shows as the wrong number of `rxc` pulses after carrier falls. The bench compares all three outputs with a model on every cycle, so any of these faults appears in the cycle it first affects a port.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_LOCK = 2'd2,
        ST_TAIL = 2'd3
    } trk_state_e;

    typedef struct packed {
        logic smp;
        logic prv;
    } in_regs_t;

endpackage

// File: rtl/mdec_insel.sv
module mdec_insel
    import mdec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic line_in,
    input  logic enc_in,
    output logic smp,
    output logic trans
);

    in_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.smp = loop_en ? enc_in : line_in;
        r_d.prv = r_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign smp   = r_q.smp;
    assign trans = r_q.smp ^ r_q.prv;

endmodule

// File: rtl/mdec_track.sv
module mdec_track
    import mdec_pkg::*;
#(
    parameter int OSR       = 8,
    parameter int LOCK_N    = 4,
    parameter int TAIL_BITS = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          trans,
    input  logic                          smp,
    output trk_state_e                    state,
    output logic [$clog2((OSR*5)/4+1)-1:0] cnt,
    output logic [$clog2(OSR)-1:0]        phase,
    output logic                          rxd
);

    localparam int MID_LO   = (OSR * 3) / 4;
    localparam int MID_HI   = (OSR * 5) / 4;
    localparam int BND_LO   = (OSR * 3) / 8;
    localparam int CW       = $clog2(MID_HI + 1);
    localparam int PW       = $clog2(OSR);
    localparam int TAIL_LEN = TAIL_BITS * OSR;
    localparam int TW       = $clog2(TAIL_LEN);
    localparam int LKW      = $clog2(LOCK_N);

    typedef struct packed {
        trk_state_e      st;
        logic [CW-1:0]   cnt;
        logic [LKW-1:0]  lk;
        logic [TW-1:0]   tcnt;
        logic            rxd;
    } trk_regs_t;

    trk_regs_t r_d, r_q;

    logic is_short;
    logic is_mid;
    logic timed_out;

    always_comb begin
        is_short  = trans && (r_q.cnt < CW'(BND_LO));
        is_mid    = trans && (r_q.cnt >= CW'(MID_LO));
        timed_out = (r_q.cnt == CW'(MID_HI));
        r_d       = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (trans) begin
                    r_d.st  = ST_ACQ;
                    r_d.cnt = CW'(1);
                    r_d.lk  = LKW'(1);
                end
            end
            ST_ACQ: begin
                if (is_short) begin
                    r_d.cnt = CW'(1);
                    r_d.lk  = LKW'(1);
                end else if (is_mid) begin
                    r_d.cnt = CW'(1);
                    if (r_q.lk == LKW'(LOCK_N - 1)) begin
                        r_d.st  = ST_LOCK;
                        r_d.rxd = smp;
                    end else begin
                        r_d.lk = r_q.lk + LKW'(1);
                    end
                end else if (timed_out) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_LOCK: begin
                if (is_mid) begin
                    r_d.cnt = CW'(1);
                    r_d.rxd = smp;
                end else if (timed_out) begin
                    r_d.st   = ST_TAIL;
                    r_d.tcnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_TAIL: begin
                if (trans) begin
                    r_d.st  = ST_ACQ;
                    r_d.cnt = CW'(1);
                    r_d.lk  = LKW'(1);
                end else if (r_q.tcnt == TW'(TAIL_LEN - 1)) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.tcnt = r_q.tcnt + TW'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.st;
    assign cnt   = r_q.cnt;
    assign phase = r_q.tcnt[PW-1:0];
    assign rxd   = r_q.rxd;

endmodule

// File: rtl/mdec_rxclk.sv
module mdec_rxclk
    import mdec_pkg::*;
#(
    parameter int OSR = 8
) (
    input  trk_state_e                     state,
    input  logic [$clog2((OSR*5)/4+1)-1:0] cnt,
    input  logic [$clog2(OSR)-1:0]         phase,
    output logic                           rxc
);

    localparam int CW    = $clog2((OSR * 5) / 4 + 1);
    localparam int PW    = $clog2(OSR);
    localparam int HI_LO = 2;
    localparam int HI_HI = 1 + OSR / 2;

    logic lock_hi;
    logic tail_hi;

    always_comb begin
        lock_hi = (state == ST_LOCK) &&
                  (cnt >= CW'(HI_LO)) && (cnt <= CW'(HI_HI));
        tail_hi = (state == ST_TAIL) &&
                  (phase >= PW'(HI_LO)) && (phase <= PW'(HI_HI));
        rxc     = lock_hi || tail_hi;
    end

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
    import mdec_pkg::*;
#(
    parameter int OSR       = 8,
    parameter int LOCK_N    = 4,
    parameter int TAIL_BITS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic line_in,
    input  logic enc_in,
    output logic crs,
    output logic rxd,
    output logic rxc
);

    localparam int CW = $clog2((OSR * 5) / 4 + 1);
    localparam int PW = $clog2(OSR);

    logic          smp_w;
    logic          trans_w;
    trk_state_e    st_w;
    logic [CW-1:0] cnt_w;
    logic [PW-1:0] ph_w;

    mdec_insel u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_en (loop_en),
        .line_in (line_in),
        .enc_in  (enc_in),
        .smp     (smp_w),
        .trans   (trans_w)
    );

    mdec_track #(
        .OSR       (OSR),
        .LOCK_N    (LOCK_N),
        .TAIL_BITS (TAIL_BITS)
    ) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .trans (trans_w),
        .smp   (smp_w),
        .state (st_w),
        .cnt   (cnt_w),
        .phase (ph_w),
        .rxd   (rxd)
    );

    mdec_rxclk #(
        .OSR (OSR)
    ) u_clk (
        .state (st_w),
        .cnt   (cnt_w),
        .phase (ph_w),
        .rxc   (rxc)
    );

    assign crs = (st_w == ST_ACQ) || (st_w == ST_LOCK);

endmodule

// File: rtl/mdec_chk.sv
module mdec_chk #(
    parameter int TAIL_BITS = 5
) (
    input logic clk,
    input logic rst_n,
    input logic loop_en,
    input logic enc_in,
    input logic smp,
    input logic crs,
    input logic rxd,
    input logic rxc
);

    logic [1:0] age_q;
    logic       rxc_q;
    logic [7:0] tails_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q   <= '0;
            rxc_q   <= 1'b0;
            tails_q <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            rxc_q <= rxc;
            if (crs) tails_q <= '0;
            else if (rxc && !rxc_q) tails_q <= tails_q + 8'd1;
        end
    end

    // R5: data is stable while the receive clock is high
    p_rxd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && rxc |-> $stable(rxd));

    // R5: every receive clock pulse lasts more than one cycle
    p_rxc_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $rose(rxc) |=> rxc);

    // R3: a new carrier never starts with the clock already running
    p_crs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0) && $rose(crs) |-> !rxc);

    // R9: in loopback the sampled input follows the encoder output
    p_loop_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) && $past(loop_en) |-> (smp == $past(enc_in)));

    // R8: no more tail pulses than the tail length once carrier is gone
    p_tail_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tails_q <= 8'(TAIL_BITS));

endmodule

bind mdec_rx mdec_chk #(.TAIL_BITS(TAIL_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .loop_en (loop_en),
    .enc_in  (enc_in),
    .smp     (smp_w),
    .crs     (crs),
    .rxd     (rxd),
    .rxc     (rxc)
);

// File: tb/tb_mdec_rx.sv
module tb_mdec_rx;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_en = 1'b0;
    logic line_in = 1'b0;
    logic enc_in = 1'b0;
    logic crs, rxd, rxc;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;

    // behavioural reference state
    int m_st = 0, m_c = 0, m_lk = 0, m_t = 0;
    int m_rxd = 0, h0 = 0, h1 = 0;

    int got[$];
    int tails = 0;
    logic rxc_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdec_rx dut (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
        .line_in(line_in), .enc_in(enc_in),
        .crs(crs), .rxd(rxd), .rxc(rxc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference: sample spacing rules of R2..R10
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_c = 0; m_lk = 0; m_t = 0; m_rxd = 0; h0 = 0; h1 = 0;
        end else begin
            bit tr;
            tr = (h1 != h0);
            if (m_st == 0) begin
                if (tr) begin m_st = 1; m_c = 1; m_lk = 1; end
            end else if (m_st == 1) begin
                if (tr && m_c < 3) begin m_c = 1; m_lk = 1; end
                else if (tr && m_c >= 6) begin
                    m_c = 1;
                    if (m_lk == 3) begin m_st = 2; m_rxd = h1; end
                    else m_lk = m_lk + 1;
                end else if (m_c == 10) m_st = 0;
                else m_c = m_c + 1;
            end else if (m_st == 2) begin
                if (tr && m_c >= 6) begin m_rxd = h1; m_c = 1; end
                else if (m_c == 10) begin m_st = 3; m_t = 0; end
                else m_c = m_c + 1;
            end else begin
                if (tr) begin m_st = 1; m_c = 1; m_lk = 1; end
                else if (m_t == 39) m_st = 0;
                else m_t = m_t + 1;
            end
            h0 = h1;
            h1 = loop_en ? int'(enc_in) : int'(line_in);
        end
    end

    // per-cycle comparison and capture, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            int e_crs, e_rxc;
            e_crs = (m_st == 1 || m_st == 2);
            e_rxc = (m_st == 2 && m_c >= 2 && m_c <= 5) ||
                    (m_st == 3 && (m_t % 8) >= 2 && (m_t % 8) <= 5);
            chk(int'(crs) == e_crs, "R2 R7 crs", int'(crs), e_crs);
            chk(int'(rxd) == m_rxd, "R4 rxd", int'(rxd), m_rxd);
            chk(int'(rxc) == e_rxc, "R5 R8 rxc", int'(rxc), e_rxc);
            if (rxc && !rxc_prev) begin
                if (crs) got.push_back(int'(rxd));
                else tails++;
            end
        end
        rxc_prev = rxc;
    end

    task automatic put(input logic v, input bit lb);
        @(negedge clk);
        if (lb) begin
            enc_in = v;
            line_in = ~line_in;
        end else begin
            line_in = v;
        end
    endtask

    task automatic send_bit(input int b, input int j, input bit lb);
        for (int k = 0; k < 4 + j; k++) put(logic'(b == 0), lb);
        for (int k = 0; k < 4 - j; k++) put(logic'(b != 0), lb);
    endtask

    task automatic quiet(input int n, input bit lb);
        for (int k = 0; k < n; k++) put(1'b0, lb);
    endtask

    task automatic run_frame(input int fr[$], input bit jit, input bit lb, input string tag);
        got.delete();
        tails = 0;
        for (int i = 0; i < fr.size(); i++)
            send_bit(fr[i], jit ? (i % 3) - 1 : 0, lb);
        quiet(70, lb);
        chk(got.size() == fr.size() - 3, {tag, " bit count"}, got.size(), fr.size() - 3);
        for (int i = 0; i < got.size() && i + 3 < fr.size(); i++)
            chk(got[i] == fr[i + 3], {tag, " bit value"}, got[i], fr[i + 3]);
        chk(tails == 5, "R8 tail pulses", tails, 5);
        chk(crs == 1'b0, "R7 carrier low after frame", int'(crs), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int fa[$];
        int fb[$];
        fa = '{1,0,1,0,1,0,1,0, 1,1,0,0,1,0,1,1,1,0,0,0,1,1,0,1};
        fb = '{1,0,1,0,1,0,1,0, 0,0,1,1,1,0,0,1,0,1,1,0,0,0,1,0};

        repeat (4) @(negedge clk);
        // R1: outputs low in reset
        chk(crs == 0 && rxd == 0 && rxc == 0, "R1 reset outputs", {crs, rxd, rxc}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(crs == 0 && rxd == 0 && rxc == 0, "R1 after release", {crs, rxd, rxc}, 0);
        cmp_on = 1;
        quiet(5, 0);

        // R3 R4 R5: clean frame
        run_frame(fa, 0, 0, "R3 R4 clean");
        // R6: frame with mid-bit jitter of one sample
        run_frame(fb, 1, 0, "R6 jitter");

        // R2 R10: short spacing restarts, then timeout without tail
        got.delete();
        tails = 0;
        @(negedge clk); line_in = 1'b1;
        @(negedge clk); line_in = 1'b0;
        @(negedge clk);
        chk(crs == 1'b1, "R2 carrier after first transition", int'(crs), 1);
        repeat (5) @(negedge clk);
        line_in = 1'b1;
        repeat (30) @(negedge clk);
        chk(crs == 1'b0, "R10 idle after acquisition timeout", int'(crs), 0);
        chk(got.size() == 0 && tails == 0, "R10 no clock before lock",
            got.size() + tails, 0);
        @(negedge clk); line_in = 1'b0;
        quiet(30, 0);

        // R9: loopback with a toggling line
        loop_en = 1'b1;
        quiet(20, 1);
        chk(crs == 1'b0, "R9 line ignored in loopback", int'(crs), 0);
        run_frame(fa, 1, 1, "R9 loopback");
        loop_en = 1'b0;
        line_in = 1'b0;
        quiet(20, 0);

        // R4: back to the line after loopback
        run_frame(fb, 0, 0, "R4 line again");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule